// File: doc/BRIEF.md
# System Bus Access Status Controller

This block is the control and status engine that sits between a debugger's register interface and a system bus master. The debugger presents read or write requests (address, size as log2 of the byte count, write data). The block checks each request, runs one bus transaction at a time over a request/response handshake, and reports progress and failures in a 32-bit status word. The status word carries a busy flag, a sticky busy-violation flag and a three-bit error code. A write to the control/status word clears flags and error bits with write-one-to-clear semantics.

The request port uses valid/ready, and `acc_ready` is held high: every request is taken in the cycle it is presented and then judged. A request that arrives while an access is in flight is dropped and raises the busy-violation flag. A request that arrives while an error or the busy-violation flag is set is dropped silently. On the bus side, `bus_req_valid` stays high with stable payload until `bus_req_ready` is seen, unless the timeout abandons the access. A response counts only after the request handshake. The read response port has no back-pressure: `rsp_valid` is a single-cycle pulse.

Top module: `sba_status_ctrl`

## Requirements
- R1: After reset the status word `cs_status` is zero and `bus_req_valid` and `rsp_valid` are low. The status word holds the busy-violation flag in bit 22, busy in bit 21 and the error code in bits 14:12; all other bits read 0. `acc_ready` is always 1.
- R2: A request is started when `acc_valid` is high, the block is not busy, the error code is 0, the busy-violation flag is clear and the request passes the size and alignment checks. From the next cycle, busy is high and `bus_req_valid` presents the request's address, size, direction and write data, held stable until a cycle with `bus_req_ready` high.
- R3: Busy stays high until a bus response arrives after the request handshake. The response clears busy at the same clock edge. A successful read then pulses `rsp_valid` for one cycle with `rsp_rdata` equal to the bus read data. A write produces no `rsp_valid`.
- R4: A response with `bus_rsp_err` = 01 sets error code 2 (bad address). Any response with `bus_rsp_err[1]` = 1 sets code 7 (other).
- R5: If an access has not completed after TIMEOUT_CYCLES cycles of busy, it is abandoned: busy drops, `bus_req_valid` falls and the error code becomes 1.
- R6: A request whose size exceeds MAX_SIZE_LOG2 sets error code 4 without raising busy or issuing a bus cycle. This check takes precedence over the alignment check.
- R7: A request whose address has any of its low `acc_size` bits set sets error code 3 without raising busy or issuing a bus cycle.
- R8: A control write while not busy clears exactly those error-code bits written as 1. For example, writing 010 to bits 14:12 turns code 7 into code 5. Bits written as 0 are kept.
- R9: The busy-violation flag is set by `cs_we` or `acc_valid` while busy. It stays set until a control write, made while not busy, has bit 22 = 1.
- R10: A control write while busy changes nothing except setting the busy-violation flag. The access in flight continues unchanged.
- R11: While the error code is nonzero or the busy-violation flag is set, a request starts no bus cycle, leaves busy low and leaves the error code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_we | input | 1 | Control/status write strobe |
| cs_wdata | input | 32 | Control/status write data (bit 22, bits 14:12 write-one-to-clear) |
| cs_status | output | 32 | Status word |
| acc_valid | input | 1 | Debugger request valid |
| acc_ready | output | 1 | Request accepted (constant 1) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Request address |
| acc_size | input | 3 | Access size, log2 of bytes |
| acc_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DW | Read data |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus request ready |
| bus_write | output | 1 | Bus direction |
| bus_addr | output | AW | Bus address |
| bus_size | output | 3 | Bus size, log2 of bytes |
| bus_wdata | output | DW | Bus write data |
| bus_rsp_valid | input | 1 | Bus response valid |
| bus_rsp_rdata | input | DW | Bus read data |
| bus_rsp_err | input | 2 | Response status: 00 ok, 01 bad address, 1x other |

## Verification
The assertions check, on every cycle, these properties: bus request payload holds until accepted or timed out; `bus_req_valid` never appears without busy; a nonzero error code stays put without a control write; gated requests never start a bus cycle; any write or request during busy raises the violation flag; busy never rises without a request. Only the directed scenarios can show the exact error code chosen for each failure, including the size-over-alignment precedence. They also show the bit-wise clearing arithmetic, the exact length of the timeout window, and the read data returned.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam int BERR_BIT = 22;
  localparam int BUSY_BIT = 21;
  localparam int ERR_LSB  = 12;
  localparam int ERR_W    = 3;
  localparam int SIZE_W   = 3;

  typedef enum logic [ERR_W-1:0] {
    ERR_NONE    = 3'd0,
    ERR_TIMEOUT = 3'd1,
    ERR_BADADDR = 3'd2,
    ERR_ALIGN   = 3'd3,
    ERR_SIZE    = 3'd4,
    ERR_OTHER   = 3'd7
  } err_code_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } bus_st_e;
endpackage

// File: rtl/sba_req_check.sv
module sba_req_check
  import sba_pkg::*;
#(
  parameter int AW            = 32,
  parameter int MAX_SIZE_LOG2 = 2
) (
  input  logic [AW-1:0]     addr,
  input  logic [SIZE_W-1:0] size,
  output logic [ERR_W-1:0]  code
);
  logic misaligned;

  always_comb begin
    misaligned = 1'b0;
    for (int i = 0; i < AW; i++) begin
      if ((i < int'(size)) && addr[i]) misaligned = 1'b1;
    end
  end

  // size violation outranks misalignment
  always_comb begin
    if (size > SIZE_W'(MAX_SIZE_LOG2)) code = ERR_SIZE;
    else if (misaligned)               code = ERR_ALIGN;
    else                               code = ERR_NONE;
  end
endmodule

// File: rtl/sba_bus_fsm.sv
module sba_bus_fsm
  import sba_pkg::*;
#(
  parameter int AW             = 32,
  parameter int DW             = 32,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              acc_write,
  input  logic [AW-1:0]     acc_addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [DW-1:0]     acc_wdata,
  output logic              busy,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_write,
  output logic [AW-1:0]     bus_addr,
  output logic [SIZE_W-1:0] bus_size,
  output logic [DW-1:0]     bus_wdata,
  input  logic              bus_rsp_valid,
  input  logic [DW-1:0]     bus_rsp_rdata,
  input  logic [1:0]        bus_rsp_err,
  output logic              fin_evt,
  output logic [ERR_W-1:0]  fin_code,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);

  bus_st_e       st_q;
  logic [CW-1:0] tmo_q;
  logic          rsp_hit, tmo_hit;

  assign busy          = (st_q != ST_IDLE);
  assign bus_req_valid = (st_q == ST_ISSUE);
  assign rsp_hit       = (st_q == ST_WAIT) && bus_rsp_valid;
  assign tmo_hit       = busy && (tmo_q == CW'(TIMEOUT_CYCLES - 1));
  assign fin_evt       = rsp_hit || tmo_hit;

  always_comb begin
    if (rsp_hit) begin
      if (bus_rsp_err[1])      fin_code = ERR_OTHER;
      else if (bus_rsp_err[0]) fin_code = ERR_BADADDR;
      else                     fin_code = ERR_NONE;
    end else if (tmo_hit) begin
      fin_code = ERR_TIMEOUT;
    end else begin
      fin_code = ERR_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      tmo_q     <= '0;
      bus_write <= 1'b0;
      bus_addr  <= '0;
      bus_size  <= '0;
      bus_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rsp_hit && (bus_rsp_err == 2'b00) && !bus_write;
      if (rsp_hit) rsp_rdata <= bus_rsp_rdata;
      case (st_q)
        ST_IDLE: begin
          tmo_q <= '0;
          if (start) begin
            st_q      <= ST_ISSUE;
            bus_write <= acc_write;
            bus_addr  <= acc_addr;
            bus_size  <= acc_size;
            bus_wdata <= acc_wdata;
          end
        end
        ST_ISSUE: begin
          tmo_q <= tmo_q + 1'b1;
          if (tmo_hit)            st_q <= ST_IDLE;
          else if (bus_req_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          tmo_q <= tmo_q + 1'b1;
          if (rsp_hit || tmo_hit) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sba_status_regs.sv
module sba_status_regs
  import sba_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             cs_we,
  input  logic             clr_berr,
  input  logic [ERR_W-1:0] clr_err,
  input  logic             acc_valid,
  input  logic             set_evt,
  input  logic [ERR_W-1:0] set_code,
  output logic [ERR_W-1:0] err_q,
  output logic             berr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= ERR_NONE;
      berr_q <= 1'b0;
    end else begin
      if (busy && (cs_we || acc_valid))   berr_q <= 1'b1;
      else if (!busy && cs_we && clr_berr) berr_q <= 1'b0;

      if (set_evt)              err_q <= set_code;
      else if (cs_we && !busy)  err_q <= err_q & ~clr_err;
    end
  end
endmodule

// File: rtl/sba_status_ctrl.sv
module sba_status_ctrl
  import sba_pkg::*;
#(
  parameter int AW             = 32,
  parameter int DW             = 32,
  parameter int MAX_SIZE_LOG2  = 2,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_we,
  input  logic [31:0]   cs_wdata,
  output logic [31:0]   cs_status,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic [2:0]    acc_size,
  input  logic [DW-1:0] acc_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          bus_req_valid,
  input  logic          bus_req_ready,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [2:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_rsp_valid,
  input  logic [DW-1:0] bus_rsp_rdata,
  input  logic [1:0]    bus_rsp_err
);
  logic             busy, berr_q, fin_evt, start, reject;
  logic [ERR_W-1:0] err_q, chk_code, fin_code;
  logic             open_gate;

  sba_req_check #(.AW(AW), .MAX_SIZE_LOG2(MAX_SIZE_LOG2)) u_check (
    .addr (acc_addr),
    .size (acc_size),
    .code (chk_code)
  );

  assign open_gate = !busy && (err_q == ERR_NONE) && !berr_q;
  assign start     = acc_valid && open_gate && (chk_code == ERR_NONE);
  assign reject    = acc_valid && open_gate && (chk_code != ERR_NONE);
  assign acc_ready = 1'b1;

  sba_bus_fsm #(.AW(AW), .DW(DW), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .acc_write     (acc_write),
    .acc_addr      (acc_addr),
    .acc_size      (acc_size),
    .acc_wdata     (acc_wdata),
    .busy          (busy),
    .bus_req_valid (bus_req_valid),
    .bus_req_ready (bus_req_ready),
    .bus_write     (bus_write),
    .bus_addr      (bus_addr),
    .bus_size      (bus_size),
    .bus_wdata     (bus_wdata),
    .bus_rsp_valid (bus_rsp_valid),
    .bus_rsp_rdata (bus_rsp_rdata),
    .bus_rsp_err   (bus_rsp_err),
    .fin_evt       (fin_evt),
    .fin_code      (fin_code),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata)
  );

  sba_status_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .cs_we     (cs_we),
    .clr_berr  (cs_wdata[BERR_BIT]),
    .clr_err   (cs_wdata[ERR_LSB +: ERR_W]),
    .acc_valid (acc_valid),
    .set_evt   (fin_evt || reject),
    .set_code  (reject ? chk_code : fin_code),
    .err_q     (err_q),
    .berr_q    (berr_q)
  );

  always_comb begin
    cs_status                   = '0;
    cs_status[BERR_BIT]         = berr_q;
    cs_status[BUSY_BIT]         = busy;
    cs_status[ERR_LSB +: ERR_W] = err_q;
  end
endmodule

// File: rtl/sba_status_ctrl_chk.sv
module sba_status_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_we,
  input logic [31:0]   cs_status,
  input logic          acc_valid,
  input logic          rsp_valid,
  input logic          bus_req_valid,
  input logic          bus_req_ready,
  input logic [AW-1:0] bus_addr
);
  logic       busy_w, berr_w;
  logic [2:0] err_w;
  assign busy_w = cs_status[21];
  assign berr_w = cs_status[22];
  assign err_w  = cs_status[14:12];

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=>
      (bus_req_valid && $stable(bus_addr)) || (err_w == 3'd1));

  // R3
  req_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> busy_w);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_w != 3'd0) && !cs_we |=> $stable(err_w));

  // R11
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !busy_w && ((err_w != 3'd0) || berr_w) |=> !bus_req_valid && !busy_w);

  // R9
  violation_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w && (cs_we || acc_valid) |=> berr_w);

  // R2
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_w) |-> $past(acc_valid));

  // R3
  rsp_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (err_w == 3'd0) && !busy_w);
endmodule

bind sba_status_ctrl sba_status_ctrl_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cs_we         (cs_we),
  .cs_status     (cs_status),
  .acc_valid     (acc_valid),
  .rsp_valid     (rsp_valid),
  .bus_req_valid (bus_req_valid),
  .bus_req_ready (bus_req_ready),
  .bus_addr      (bus_addr)
);

// File: tb/sba_status_ctrl_tb.sv
module sba_status_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int TMO = 16;
  localparam logic [31:0] CLR_ALL = 32'h0040_7000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_we = 1'b0;
  logic [31:0]   cs_wdata = '0;
  logic [31:0]   cs_status;
  logic          acc_valid = 1'b0;
  logic          acc_ready;
  logic          acc_write = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [2:0]    acc_size = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          bus_req_valid;
  logic          bus_req_ready = 1'b0;
  logic          bus_write;
  logic [AW-1:0] bus_addr;
  logic [2:0]    bus_size;
  logic [DW-1:0] bus_wdata;
  logic          bus_rsp_valid = 1'b0;
  logic [DW-1:0] bus_rsp_rdata = '0;
  logic [1:0]    bus_rsp_err = '0;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sba_status_ctrl #(.AW(AW), .DW(DW), .MAX_SIZE_LOG2(2), .TIMEOUT_CYCLES(TMO)) u_dut (
    .clk, .rst_n, .cs_we, .cs_wdata, .cs_status,
    .acc_valid, .acc_ready, .acc_write, .acc_addr, .acc_size, .acc_wdata,
    .rsp_valid, .rsp_rdata,
    .bus_req_valid, .bus_req_ready, .bus_write, .bus_addr, .bus_size, .bus_wdata,
    .bus_rsp_valid, .bus_rsp_rdata, .bus_rsp_err
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [2:0] err_of();
    return cs_status[14:12];
  endfunction

  task automatic cs_write(input logic [31:0] d);
    cs_we = 1'b1; cs_wdata = d;
    step();
    cs_we = 1'b0; cs_wdata = '0;
  endtask

  task automatic start_acc(input logic w, input logic [31:0] a, input logic [2:0] s,
                           input logic [31:0] d);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_size = s; acc_wdata = d;
    step();
    acc_valid = 1'b0;
  endtask

  task automatic finish_acc(input logic [1:0] e, input logic [31:0] rd);
    bus_req_ready = 1'b1;
    step();
    bus_req_ready = 1'b0;
    bus_rsp_valid = 1'b1; bus_rsp_err = e; bus_rsp_rdata = rd;
    step();
    bus_rsp_valid = 1'b0; bus_rsp_err = '0;
  endtask

  task automatic t_reset();
    step(); step();
    chk("R1 status at reset", cs_status, 32'h0);
    chk("R1 bus_req_valid at reset", {31'd0, bus_req_valid}, 32'd0);
    chk("R1 rsp_valid at reset", {31'd0, rsp_valid}, 32'd0);
    chk("R1 acc_ready", {31'd0, acc_ready}, 32'd1);
    rst_n = 1'b1;
    step();
    chk("R1 status after release", cs_status, 32'h0);
  endtask

  task automatic t_read_ok();
    start_acc(1'b0, 32'h0000_0100, 3'd2, '0);
    chk("R2 busy after accept", cs_status, 32'h0020_0000);
    chk("R2 bus_req_valid", {31'd0, bus_req_valid}, 32'd1);
    chk("R2 bus_addr", bus_addr, 32'h0000_0100);
    chk("R2 bus_size", {29'd0, bus_size}, 32'd2);
    step();
    chk("R2 request held", {bus_req_valid, bus_addr[30:0]}, {1'b1, 31'h100});
    bus_req_ready = 1'b1;
    step();
    bus_req_ready = 1'b0;
    chk("R3 request dropped after handshake", {31'd0, bus_req_valid}, 32'd0);
    chk("R3 busy while waiting", {31'd0, cs_status[21]}, 32'd1);
    step();
    bus_rsp_valid = 1'b1; bus_rsp_rdata = 32'hCAFE_F00D;
    step();
    bus_rsp_valid = 1'b0;
    chk("R3 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk("R3 rsp_rdata", rsp_rdata, 32'hCAFE_F00D);
    chk("R3 idle after read", cs_status, 32'h0);
    step();
    chk("R3 rsp_valid one cycle", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_write_ok();
    start_acc(1'b1, 32'h0000_0204, 3'd2, 32'h1234_5678);
    chk("R2 bus_write", {31'd0, bus_write}, 32'd1);
    chk("R2 bus_wdata", bus_wdata, 32'h1234_5678);
    finish_acc(2'b00, 32'h0);
    chk("R3 no rsp for write", {31'd0, rsp_valid}, 32'd0);
    chk("R3 idle after write", cs_status, 32'h0);
  endtask

  task automatic t_bus_err();
    start_acc(1'b0, 32'h0000_0300, 3'd2, '0);
    finish_acc(2'b01, 32'h0);
    chk("R4 bad address code", {29'd0, err_of()}, 32'd2);
    chk("R4 no rsp on error", {31'd0, rsp_valid}, 32'd0);
    cs_write(CLR_ALL);
    chk("R8 cleared", cs_status, 32'h0);
    start_acc(1'b1, 32'h0000_0300, 3'd1, 32'h55);
    finish_acc(2'b10, 32'h0);
    chk("R4 other code", {29'd0, err_of()}, 32'd7);
    cs_write(32'h0000_2000);
    chk("R8 partial clear 7->5", {29'd0, err_of()}, 32'd5);
    cs_write(32'h0000_0000);
    chk("R8 zero write keeps", {29'd0, err_of()}, 32'd5);
    cs_write(32'h0000_7000);
    chk("R8 full clear", cs_status, 32'h0);
  endtask

  task automatic t_timeout();
    start_acc(1'b0, 32'h0000_0400, 3'd2, '0);
    for (int i = 1; i < TMO; i++) step();
    chk("R5 busy through window", {31'd0, cs_status[21]}, 32'd1);
    step();
    chk("R5 timeout status", cs_status, 32'h0000_1000);
    chk("R5 request abandoned", {31'd0, bus_req_valid}, 32'd0);
    cs_write(CLR_ALL);
  endtask

  task automatic t_size();
    start_acc(1'b0, 32'h0000_0101, 3'd3, '0);
    chk("R6 size code wins over align", cs_status, 32'h0000_4000);
    chk("R6 no bus cycle", {31'd0, bus_req_valid}, 32'd0);
    cs_write(CLR_ALL);
    start_acc(1'b0, 32'h0000_0103, 3'd0, '0);
    chk("R7 byte access any address", {31'd0, cs_status[21]}, 32'd1);
    finish_acc(2'b00, 32'h0000_00AB);
    chk("R3 byte read data", rsp_rdata, 32'h0000_00AB);
  endtask

  task automatic t_align();
    start_acc(1'b0, 32'h0000_0102, 3'd2, '0);
    chk("R7 align code", cs_status, 32'h0000_3000);
    chk("R7 no bus cycle", {31'd0, bus_req_valid}, 32'd0);
  endtask

  task automatic t_gate();
    start_acc(1'b0, 32'h0000_0100, 3'd2, '0);
    chk("R11 gated by error", cs_status, 32'h0000_3000);
    chk("R11 no bus cycle", {31'd0, bus_req_valid}, 32'd0);
    cs_write(CLR_ALL);
    chk("R8 clear after gate", cs_status, 32'h0);
  endtask

  task automatic t_busyerr();
    start_acc(1'b0, 32'h0000_0500, 3'd2, '0);
    cs_write(CLR_ALL);
    chk("R9 set by write while busy", cs_status, 32'h0060_0000);
    chk("R10 request continues", {bus_req_valid, bus_addr[30:0]}, {1'b1, 31'h500});
    start_acc(1'b1, 32'h0000_0600, 3'd2, '0);
    chk("R9 request while busy ignored", {bus_write, bus_addr[30:0]}, {1'b0, 31'h500});
    finish_acc(2'b00, 32'h0000_1111);
    chk("R10 access completes", {31'd0, rsp_valid}, 32'd1);
    chk("R9 flag stays", cs_status, 32'h0040_0000);
    start_acc(1'b0, 32'h0000_0100, 3'd2, '0);
    chk("R11 gated by violation", cs_status, 32'h0040_0000);
    cs_write(32'h0000_7000);
    chk("R9 not cleared without bit22", cs_status, 32'h0040_0000);
    cs_write(32'h0040_0000);
    chk("R9 cleared", cs_status, 32'h0);
    start_acc(1'b0, 32'h0000_0100, 3'd2, '0);
    chk("R2 restart after clear", {31'd0, cs_status[21]}, 32'd1);
    finish_acc(2'b00, 32'h0);
  endtask

  initial begin
    t_reset();
    t_read_ok();
    t_write_ok();
    t_bus_err();
    t_timeout();
    t_size();
    t_align();
    t_gate();
    t_busyerr();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule